// File: doc/BRIEF.md
# Thermal Alarm Output Controller

This block turns a stream of temperature samples into one overtemperature alarm pin. Each accepted sample is tested against a trip limit and a lower release limit. A run of consecutive faulting samples must be seen before the alarm changes state. The required run length is programmable. Two behaviours are available. In thermostat mode the alarm follows the temperature with hysteresis. In latched mode the alarm holds until the host reads any register. It then waits for a crossing of the other limit. The block that owns the bus and the register bank wires its limit and configuration registers straight onto the ports. It gives the block a one-cycle pulse for every register read. The package holds the power-up values that register bank should load: trip 80 °C (code 160), release 75 °C (code 150), configuration 0x00 (running, thermostat mode, active-low pin, run length 1).

Temperatures and limits are 9-bit two's-complement numbers in half-degree steps. The configuration byte is decoded as follows. Bit 0 means halted when 1. Bit 1 selects thermostat mode (0) or latched mode (1). Bit 2 selects the active pin level: 0 is low and 1 is high. Bits 4:3 hold the run-length code. Bits 7:5 have no effect.

Top module: `thalarm_ctrl`

## Requirements
- R1: After reset the alarm is inactive and latched mode is armed on the trip limit. The pin shows the inactive level, which is the inverse of configuration bit 2.
- R2: In thermostat mode an inactive alarm goes active once enough consecutive accepted samples are strictly greater than the trip limit. A sample equal to the trip limit is not a fault.
- R3: In thermostat mode an active alarm goes inactive once enough consecutive accepted samples are strictly less than the release limit. A sample equal to the release limit is not a fault.
- R4: In thermostat mode, register-read pulses and a halt (configuration bit 0 = 1) leave the alarm state unchanged.
- R5: In latched mode the first activation after reset needs samples above the trip limit. The alarm then stays active, whatever the samples are, until a read pulse arrives.
- R6: In latched mode each read that clears an active alarm swaps the armed limit: trip, then release, then trip again. A read while the alarm is inactive does nothing.
- R7: In latched mode a halt clears the alarm and re-arms the trip limit. While halted, samples are ignored and the run count stays at zero, in either mode.
- R8: Run-length code 00 needs 1 sample, 01 needs 2, 10 needs 4 and 11 needs 6 consecutive faulting samples. A non-faulting accepted sample restarts the count.
- R9: With configuration bit 2 = 1 the pin is high when the alarm is active. With bit 2 = 0 it is low when the alarm is active.
- R10: All comparisons between samples and limits are signed, so negative limits and samples order correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe: a new sample is on smp_temp |
| smp_temp | input | 9 | Sample, signed, 0.5 °C per LSB |
| lim_trip | input | 9 | Trip limit, signed, 0.5 °C per LSB |
| lim_rel | input | 9 | Release limit, signed, 0.5 °C per LSB |
| cfg | input | 8 | Configuration byte (bit 0 halt, bit 1 mode, bit 2 polarity, bits 4:3 run-length code) |
| reg_rd | input | 1 | One-cycle pulse for any host register read |
| alarm_pin | output | 1 | Alarm output at the selected polarity |

## Verification
The alarm state has no path to the pins except alarm_pin. A corrupted state therefore shows up as a wrong pin level, either right away or at the next accepted sample. In latched mode a wrong armed limit stays hidden until the next read has cleared the alarm. It then shows as a missing or spurious activation on the following sample. A miscounted run shows as an alarm that changes one or more samples too early or too late. The bench therefore walks every run-length code to its exact boundary and checks the pin after each sample.

// File: rtl/thalarm_pkg.sv
package thalarm_pkg;

   // limit watched next in latched mode
   typedef enum logic {
      ARM_TRIP = 1'b0,
      ARM_REL  = 1'b1
   } arm_e;

   // configuration byte bit positions
   localparam int CFG_HALT  = 0;
   localparam int CFG_MODE  = 1;
   localparam int CFG_POL   = 2;
   localparam int CFG_RL_LO = 3;
   localparam int CFG_RL_W  = 2;

   // power-up values for the register bank that feeds this block
   localparam logic [8:0] DEF_TRIP = 9'd160;
   localparam logic [8:0] DEF_REL  = 9'd150;
   localparam logic [7:0] DEF_CFG  = 8'h00;

   localparam int RUN_MAX = 6;

   function automatic int unsigned run_len(input logic [CFG_RL_W-1:0] code);
      case (code)
         2'b00:   return 1;
         2'b01:   return 2;
         2'b10:   return 4;
         default: return 6;
      endcase
   endfunction

endpackage

// File: rtl/thalarm_cmp.sv
module thalarm_cmp
   import thalarm_pkg::*;
#(
   parameter int TW     = 9,
   parameter bit SIGNED = 1'b1
) (
   input  logic [TW-1:0] temp,
   input  logic [TW-1:0] lim_trip,
   input  logic [TW-1:0] lim_rel,
   input  arm_e          watch,
   output logic          fault
);

   logic above_trip;
   logic below_rel;

   generate
      if (SIGNED) begin : g_signed
         assign above_trip = $signed(temp) > $signed(lim_trip);
         assign below_rel  = $signed(temp) < $signed(lim_rel);
      end else begin : g_unsigned
         assign above_trip = temp > lim_trip;
         assign below_rel  = temp < lim_rel;
      end
   endgenerate

   assign fault = (watch == ARM_REL) ? below_rel : above_trip;

endmodule

// File: rtl/thalarm_runq.sv
module thalarm_runq
   import thalarm_pkg::*;
#(
   parameter int RW = 2,
   parameter int MAXLEN = RUN_MAX,
   localparam int CW = $clog2(MAXLEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          smp_en,
   input  logic          fault,
   input  logic [RW-1:0] code,
   output logic          evt,
   output logic [CW-1:0] cnt
);

   logic [CW-1:0] need;
   logic [CW-1:0] cnt_nx;
   logic          done;

   assign need   = CW'(run_len(code));
   assign cnt_nx = cnt + 1'b1;
   assign done   = (cnt_nx >= need);
   assign evt    = smp_en & fault & done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (smp_en) begin
         if (fault && !done) cnt <= cnt_nx;
         else                cnt <= '0;
      end
   end

   // R8: the count never reaches the required length
   p_cnt_below_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < need || $changed(code));

   // R7: a halted or latched queue stays empty
   p_clr_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/thalarm_state.sv
module thalarm_state
   import thalarm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic latch_mode,
   input  logic halt,
   input  logic rd,
   input  logic evt,
   output logic active,
   output arm_e arm
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         arm    <= ARM_TRIP;
      end else if (latch_mode) begin
         if (halt) begin
            active <= 1'b0;
            arm    <= ARM_TRIP;
         end else if (active) begin
            if (rd) begin
               active <= 1'b0;
               arm    <= (arm == ARM_TRIP) ? ARM_REL : ARM_TRIP;
            end
         end else if (evt) begin
            active <= 1'b1;
         end
      end else begin
         arm <= ARM_TRIP;
         if (evt) active <= ~active;
      end
   end

   // R4: thermostat state moves only on a queue event
   p_thermo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_mode && !evt) |=> $stable(active));

   // R7: halt in latched mode clears and re-arms
   p_halt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_mode && halt) |=> (!active && arm == ARM_TRIP));

   // R6: clearing read swaps the armed limit
   p_arm_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_mode && !halt && active && rd) |=> (arm != $past(arm)));

   // R5: latched alarm holds without a read or halt
   p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_mode && active && !rd && !halt) |=> active);

endmodule

// File: rtl/thalarm_ctrl.sv
module thalarm_ctrl
   import thalarm_pkg::*;
#(
   parameter int TW      = 9,
   parameter bit SIGNED  = 1'b1,
   parameter bit OUT_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_vld,
   input  logic [TW-1:0] smp_temp,
   input  logic [TW-1:0] lim_trip,
   input  logic [TW-1:0] lim_rel,
   input  logic [7:0]    cfg,
   input  logic          reg_rd,
   output logic          alarm_pin
);

   localparam int CW = $clog2(RUN_MAX + 1);

   generate
      if (TW < 4) begin : g_bad_tw
         $error("thalarm_ctrl: TW must be at least 4");
      end
      if (CFG_RL_LO + CFG_RL_W > 8) begin : g_bad_cfg
         $error("thalarm_ctrl: run-length field exceeds configuration byte");
      end
   endgenerate

   logic                halt;
   logic                latch_mode;
   logic                pol_hi;
   logic [CFG_RL_W-1:0] rl_code;
   logic                active;
   arm_e                arm;
   arm_e                watch;
   logic                fault;
   logic                evt;
   logic                q_clr;
   logic                q_en;
   logic [CW-1:0]       q_cnt;
   logic                pin_nx;

   assign halt       = cfg[CFG_HALT];
   assign latch_mode = cfg[CFG_MODE];
   assign pol_hi     = cfg[CFG_POL];
   assign rl_code    = cfg[CFG_RL_LO +: CFG_RL_W];

   assign watch = latch_mode ? arm : (active ? ARM_REL : ARM_TRIP);
   assign q_clr = halt | (latch_mode & active);
   assign q_en  = smp_vld & ~q_clr;

   thalarm_cmp #(.TW(TW), .SIGNED(SIGNED)) u_cmp (
      .temp     (smp_temp),
      .lim_trip (lim_trip),
      .lim_rel  (lim_rel),
      .watch    (watch),
      .fault    (fault)
   );

   thalarm_runq #(.RW(CFG_RL_W), .MAXLEN(RUN_MAX)) u_runq (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (q_clr),
      .smp_en (q_en),
      .fault  (fault),
      .code   (rl_code),
      .evt    (evt),
      .cnt    (q_cnt)
   );

   thalarm_state u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .latch_mode (latch_mode),
      .halt       (halt),
      .rd         (reg_rd),
      .evt        (evt),
      .active     (active),
      .arm        (arm)
   );

   assign pin_nx = pol_hi ? active : ~active;

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) alarm_pin <= ~cfg[CFG_POL];
            else        alarm_pin <= pin_nx;
         end
      end else begin : g_out_comb
         assign alarm_pin = pin_nx;
      end
   endgenerate

   // R7: a halted block keeps the queue empty on the next cycle
   p_halt_no_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (q_cnt == '0));

   // R2: thermostat activation only follows a sample
   p_rise_needs_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_mode && !active && !smp_vld) |=> !active);

endmodule

// File: tb/thalarm_ctrl_tb_top.sv
`timescale 1ns/1ps
module thalarm_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_vld = 1'b0;
   logic [8:0] smp_temp = '0;
   logic [8:0] lim_trip = 9'd160;
   logic [8:0] lim_rel = 9'd150;
   logic [7:0] cfg = 8'h00;
   logic       reg_rd = 1'b0;
   logic       alarm_pin;

   int nvec = 0;
   int nbad = 0;
   string cur_req = "R1";

   // reference state
   int m_act = 0;
   int m_arm = 0;
   int m_cnt = 0;

   always #5 clk = ~clk;

   thalarm_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_temp(smp_temp),
      .lim_trip(lim_trip), .lim_rel(lim_rel), .cfg(cfg), .reg_rd(reg_rd),
      .alarm_pin(alarm_pin)
   );

   function automatic int sx(input logic [8:0] v);
      return int'($signed(v));
   endfunction

   function automatic int need_of(input logic [1:0] c);
      return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : (c == 2'b10) ? 4 : 6;
   endfunction

   // behavioural reference, updated each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_arm = 0; m_cnt = 0;
      end else begin
         automatic bit im = cfg[1];
         automatic bit flt;
         if (cfg[0]) begin
            m_cnt = 0;
            if (im) begin m_act = 0; m_arm = 0; end
         end else if (im && m_act == 1) begin
            m_cnt = 0;
            if (reg_rd) begin m_act = 0; m_arm = 1 - m_arm; end
         end else if (smp_vld) begin
            if ((im && m_arm == 1) || (!im && m_act == 1))
               flt = sx(smp_temp) < sx(lim_rel);
            else
               flt = sx(smp_temp) > sx(lim_trip);
            if (flt) begin
               m_cnt++;
               if (m_cnt >= need_of(cfg[4:3])) begin
                  m_cnt = 0;
                  m_act = im ? 1 : 1 - m_act;
               end
            end else begin
               m_cnt = 0;
            end
         end
         if (!im) m_arm = 0;
      end
   end

   // compare every cycle, 3 ns after the falling edge
   always begin
      @(negedge clk);
      #3;
      begin
         automatic logic exp = cfg[2] ? logic'(m_act) : ~logic'(m_act);
         nvec++;
         if (alarm_pin !== exp) begin
            nbad++;
            $display("FAIL %s cycle compare: alarm_pin=%b expected=%b at %0t",
                     cur_req, alarm_pin, exp, $time);
         end
      end
   end

   task automatic expect_pin(input logic e, input string r);
      #1;
      nvec++;
      if (alarm_pin !== e) begin
         nbad++;
         $display("FAIL %s directed: alarm_pin=%b expected=%b at %0t", r, alarm_pin, e, $time);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic step(input int t);
      smp_temp = 9'(t);
      smp_vld = 1'b1;
      @(negedge clk);
      smp_vld = 1'b0;
   endtask

   task automatic rd_pulse();
      reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic halt_pulse(input int t);
      cfg[0] = 1'b1;
      smp_temp = 9'(t);
      smp_vld = 1'b1;
      @(negedge clk);
      smp_vld = 1'b0;
      cfg[0] = 1'b0;
   endtask

   task automatic set_cfg(input logic [1:0] rl, input bit pol, input bit lm);
      cfg = {3'b000, rl, pol, lm, 1'b0};
   endtask

   initial begin
      #2_000_000;
      nbad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      expect_pin(1'b1, "R1");

      // thermostat, run length 1
      set_cfg(2'b00, 0, 0);
      cur_req = "R2";
      step(160); expect_pin(1'b1, "R2");
      step(161); expect_pin(1'b0, "R2");

      cur_req = "R4";
      rd_pulse();      expect_pin(1'b0, "R4");
      halt_pulse(10);  expect_pin(1'b0, "R4");

      cur_req = "R3";
      step(150); expect_pin(1'b0, "R3");
      step(149); expect_pin(1'b1, "R3");

      // run-length codes
      cur_req = "R8";
      set_cfg(2'b10, 0, 0);
      repeat (3) step(170);
      expect_pin(1'b1, "R8");
      step(150);
      repeat (3) step(170);
      expect_pin(1'b1, "R8");
      step(170); expect_pin(1'b0, "R8");
      set_cfg(2'b11, 0, 0);
      repeat (5) step(100);
      expect_pin(1'b0, "R8");
      step(100); expect_pin(1'b1, "R8");
      set_cfg(2'b01, 0, 0);
      step(170); step(100); step(170);
      expect_pin(1'b1, "R8");
      step(170); expect_pin(1'b0, "R8");

      cur_req = "R9";
      set_cfg(2'b01, 1, 0);
      @(negedge clk);
      expect_pin(1'b1, "R9");
      set_cfg(2'b00, 1, 0);
      step(100); expect_pin(1'b0, "R9");

      // signed limits
      cur_req = "R10";
      lim_trip = 9'(-20);
      lim_rel  = 9'(-40);
      step(-20); expect_pin(1'b0, "R10");
      step(-19); expect_pin(1'b1, "R10");
      step(-40); expect_pin(1'b1, "R10");
      step(-41); expect_pin(1'b0, "R10");
      step(255); expect_pin(1'b1, "R10");
      step(-100); expect_pin(1'b0, "R10");
      lim_trip = 9'd160;
      lim_rel  = 9'd150;

      // latched mode
      cur_req = "R5";
      set_cfg(2'b00, 0, 1);
      halt_pulse(200); expect_pin(1'b1, "R7");
      step(161); expect_pin(1'b0, "R5");
      step(100); expect_pin(1'b0, "R5");
      step(140); expect_pin(1'b0, "R5");
      rd_pulse(); expect_pin(1'b1, "R5");

      cur_req = "R6";
      step(200); expect_pin(1'b1, "R6");
      step(140); expect_pin(1'b0, "R6");
      rd_pulse(); expect_pin(1'b1, "R6");
      step(140); expect_pin(1'b1, "R6");
      step(161); expect_pin(1'b0, "R6");

      cur_req = "R7";
      halt_pulse(200); expect_pin(1'b1, "R7");
      step(140); expect_pin(1'b1, "R7");
      step(161); expect_pin(1'b0, "R7");
      rd_pulse(); expect_pin(1'b1, "R7");

      cur_req = "R6";
      rd_pulse(); expect_pin(1'b1, "R6");
      step(161); expect_pin(1'b1, "R6");
      step(140); expect_pin(1'b0, "R6");

      cur_req = "R8";
      rd_pulse();
      set_cfg(2'b01, 0, 1);
      step(170); expect_pin(1'b1, "R8");
      step(170); expect_pin(1'b0, "R8");
      rd_pulse(); expect_pin(1'b1, "R8");

      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule